// File: doc/BRIEF.md
# Multi-Lane Link Recovery Monitor

This block watches the receive side of a multi-lane 10G-class PCS, two lanes by default, and steers each lane back to a working link on its own. A free-running counter produces an evaluation tick once every `TICK_CYCLES` clocks, which stands for the 100 ms supervision period. On each tick every lane samples three inputs: its loss-of-signal flag, its block-lock flag and its 8-bit block error count. The loss and lock flags are first passed through a two-flop synchronizer. Each lane then advances a small state machine with three states: syncing, linked and suspect.

From that state machine each lane drives a 2-bit signal-detect override field. The field is held at 3 once the link is good. It is pulsed to 2 for `PULSE_CYCLES` clocks, standing for 1 ms, when a clock-data-recovery reset is needed. After the pulse it returns to 0. A CDR reset is only issued when the lane's loop-filter reading falls outside a window. The reading is a 12-bit diagnostic value with its two low bits dropped.

Each lane also issues a two-step command on its 8-bit error control field that clears its error counter. It flags a lane-down event when a linked lane loses lock. The block combines the lanes into one link-up flag. It raises a sticky timeout if the first two evaluations after reset both fail to bring every lane up.

Top module: `lane_supervisor`

## Requirements
- R1: After reset, every lane is in syncing, every override field is 0, every error control field is 0x00, and lane_down_o, link_up_o and timeout_o are 0.
- R2: A syncing lane with loss clear and effective lock set drives its override field to 3 and becomes linked. A syncing lane with loss set and lock set stays syncing, requests no CDR check and leaves its override field unchanged.
- R3: A CDR check forms the loop-filter value as the 12-bit diagnostic input shifted right by two. If that value is below 400 or above 700, the override field becomes 2 for exactly PULSE_CYCLES clocks and then 0. For values from 400 to 700 inclusive the override field is left unchanged. A syncing lane without effective lock requests a CDR check.
- R4: An error count of 0xFF counts as no block lock for that evaluation, whatever the lock input says.
- R5: A linked lane without effective lock pulses its lane_down_o bit high for one clock and becomes suspect. Its override field stays 3.
- R6: A suspect lane that has effective lock again becomes linked. It raises no lane-down flag and issues no CDR reset.
- R7: A suspect lane that still lacks effective lock requests a CDR check and returns to syncing. A later evaluation without lock then raises no lane-down flag.
- R8: When a lane's error count is nonzero at an evaluation, its error control field reads 0x19 for the one clock after the evaluation and 0x00 on the clock after that.
- R9: link_up_o is 1 exactly when every lane is linked.
- R10: timeout_o rises one clock after the second evaluation after reset if neither of the first two evaluations found all lanes linked. It then stays 1 until reset. Once all lanes have been linked at an evaluation, timeout_o never rises.
- R11: Evaluations happen only at ticks, one every TICK_CYCLES clocks. Loss and lock pass through two flops, so a change made less than two clocks before a tick is seen only at the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_i | input | NUM_LANES | Per-lane loss-of-signal flag (asynchronous) |
| lock_i | input | NUM_LANES | Per-lane block-lock flag (asynchronous) |
| err_cnt_i | input | NUM_LANES*ERR_W | Per-lane block error count, lane 0 in the low bits |
| diag_i | input | NUM_LANES*DIAG_W | Per-lane CDR diagnostic value, lane 0 in the low bits |
| sigdet_ovr_o | output | 2*NUM_LANES | Per-lane signal-detect override field, lane 0 in the low bits |
| err_ctrl_o | output | NUM_LANES*ERR_W | Per-lane error control field |
| lane_down_o | output | NUM_LANES | One-clock per-lane lane-down pulse |
| link_up_o | output | 1 | All lanes linked |
| timeout_o | output | 1 | Sticky link-up timeout |

## Verification
Two functions can fall on the same evaluation. One is the error-saturation override of the lock input. The other is the two-step counter clear. A linked lane is given lock asserted together with an error count of 0xFF. The bench then expects both effects one clock after that tick: a lane-down pulse on that lane and 0x19 on its error control field, followed by 0x00 one clock later. A second overlap is also checked. A CDR pulse that starts on one lane must not disturb the other lane's held override of 3 or the aggregate flag.

// File: rtl/lss_pkg.sv
package lss_pkg;

  typedef enum logic [1:0] {
    ST_SYNC    = 2'd0,
    ST_LINKED  = 2'd1,
    ST_SUSPECT = 2'd2
  } lane_state_e;

  function automatic int loop_filter(input int diag);
    return diag / 4;
  endfunction

  function automatic logic outside_window(input int lf, input int lo, input int hi);
    return (lf < lo) || (lf > hi);
  endfunction

endpackage

// File: rtl/lss_tick_gen.sv
module lss_tick_gen #(
  parameter int TICK_CYCLES = 15625000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r11_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/lss_sync.sv
module lss_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lss_lane.sv
module lss_lane
  import lss_pkg::*;
#(
  parameter int ERR_W        = 8,
  parameter int DIAG_W       = 12,
  parameter int PULSE_CYCLES = 156250,
  parameter int LF_LO        = 400,
  parameter int LF_HI        = 700,
  parameter logic [ERR_W-1:0] CLR_CODE = ERR_W'(8'h19)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              los_i,
  input  logic              lock_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic [DIAG_W-1:0] diag_i,
  output logic [1:0]        ovr_o,
  output logic [ERR_W-1:0]  err_ctrl_o,
  output logic              down_o,
  output logic              linked_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYCLES - 1);
  localparam logic [ERR_W-1:0] ERR_SAT = {ERR_W{1'b1}};

  logic [1:0]       state_q, state_nxt;
  logic [1:0]       ovr_q;
  logic [PW-1:0]    pulse_cnt_q;
  logic             pulse_act_q;
  logic [ERR_W-1:0] err_ctrl_q;
  logic             down_q;

  // named internal events
  logic eff_lock;
  logic set_linked_ovr;
  logic cdr_req;
  logic cdr_fire;
  logic down_set;
  logic err_seen;

  assign eff_lock = lock_i && (err_i != ERR_SAT);
  assign err_seen = (err_i != '0);
  assign cdr_fire = cdr_req &&
                    outside_window(loop_filter(int'(diag_i)), LF_LO, LF_HI);

  always_comb begin
    state_nxt      = state_q;
    set_linked_ovr = 1'b0;
    cdr_req        = 1'b0;
    down_set       = 1'b0;
    case (state_q)
      ST_SYNC: begin
        if (!los_i && eff_lock) begin
          state_nxt      = ST_LINKED;
          set_linked_ovr = 1'b1;
        end else if (!eff_lock) begin
          cdr_req = 1'b1;
        end
      end
      ST_LINKED: begin
        if (!eff_lock) begin
          down_set  = 1'b1;
          state_nxt = ST_SUSPECT;
        end
      end
      ST_SUSPECT: begin
        if (eff_lock) begin
          state_nxt = ST_LINKED;
        end else begin
          cdr_req   = 1'b1;
          state_nxt = ST_SYNC;
        end
      end
      default: state_nxt = ST_SYNC;
    endcase
  end

  // state, down flag and error clear sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_SYNC;
      down_q     <= 1'b0;
      err_ctrl_q <= '0;
    end else if (tick_i) begin
      state_q    <= state_nxt;
      down_q     <= down_set;
      err_ctrl_q <= err_seen ? CLR_CODE : '0;
    end else begin
      down_q     <= 1'b0;
      err_ctrl_q <= '0;
    end
  end

  // signal-detect override field and CDR reset pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q       <= 2'd0;
      pulse_act_q <= 1'b0;
      pulse_cnt_q <= '0;
    end else if (tick_i && set_linked_ovr) begin
      ovr_q       <= 2'd3;
      pulse_act_q <= 1'b0;
      pulse_cnt_q <= '0;
    end else if (tick_i && cdr_fire) begin
      ovr_q       <= 2'd2;
      pulse_act_q <= 1'b1;
      pulse_cnt_q <= PULSE_LOAD;
    end else if (pulse_act_q) begin
      if (pulse_cnt_q == '0) begin
        ovr_q       <= 2'd0;
        pulse_act_q <= 1'b0;
      end else begin
        pulse_cnt_q <= pulse_cnt_q - 1'b1;
      end
    end
  end

  assign ovr_o      = ovr_q;
  assign err_ctrl_o = err_ctrl_q;
  assign down_o     = down_q;
  assign linked_o   = (state_q == ST_LINKED);

  a_r3_field_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q != 2'd1);
  a_r2_linked_holds_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LINKED) |-> (ovr_q == 2'd3));
  a_r4_sat_blocks_link: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && state_q == ST_SYNC && err_i == ERR_SAT) |=> (state_q != ST_LINKED));
  a_r5_down_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    down_q |-> $past(tick_i));
  a_r5_down_means_suspect: assert property (@(posedge clk) disable iff (!rst_n)
    down_q |-> (state_q == ST_SUSPECT));
  a_r8_clear_second_step: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ctrl_q == CLR_CODE) |=> (err_ctrl_q == '0));
endmodule

// File: rtl/lane_supervisor.sv
module lane_supervisor #(
  parameter int NUM_LANES    = 2,
  parameter int ERR_W        = 8,
  parameter int DIAG_W       = 12,
  parameter int TICK_CYCLES  = 15625000,
  parameter int PULSE_CYCLES = 156250,
  parameter int LF_LO        = 400,
  parameter int LF_HI        = 700,
  parameter int MAX_ATTEMPTS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LANES-1:0]        los_i,
  input  logic [NUM_LANES-1:0]        lock_i,
  input  logic [NUM_LANES*ERR_W-1:0]  err_cnt_i,
  input  logic [NUM_LANES*DIAG_W-1:0] diag_i,
  output logic [2*NUM_LANES-1:0]      sigdet_ovr_o,
  output logic [NUM_LANES*ERR_W-1:0]  err_ctrl_o,
  output logic [NUM_LANES-1:0]        lane_down_o,
  output logic                        link_up_o,
  output logic                        timeout_o
);
  localparam int AW = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [AW-1:0] ATT_MAX = AW'(MAX_ATTEMPTS);

  logic                   tick;
  logic                   tick_q;
  logic [NUM_LANES-1:0]   los_s, lock_s;
  logic [NUM_LANES-1:0]   linked;
  logic [AW-1:0]          fails_q;
  logic                   seen_up_q;
  logic                   timeout_q;

  lss_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  lss_sync #(.W(2*NUM_LANES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({los_i, lock_i}),
    .q_o({los_s, lock_s})
  );

  genvar l;
  generate
    for (l = 0; l < NUM_LANES; l++) begin : g_lane
      lss_lane #(
        .ERR_W(ERR_W), .DIAG_W(DIAG_W), .PULSE_CYCLES(PULSE_CYCLES),
        .LF_LO(LF_LO), .LF_HI(LF_HI)
      ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .los_i     (los_s[l]),
        .lock_i    (lock_s[l]),
        .err_i     (err_cnt_i[l*ERR_W +: ERR_W]),
        .diag_i    (diag_i[l*DIAG_W +: DIAG_W]),
        .ovr_o     (sigdet_ovr_o[2*l +: 2]),
        .err_ctrl_o(err_ctrl_o[l*ERR_W +: ERR_W]),
        .down_o    (lane_down_o[l]),
        .linked_o  (linked[l])
      );
    end
  endgenerate

  assign link_up_o = &linked;

  // attempt bookkeeping for the link-up timeout, judged one clock after a tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q    <= 1'b0;
      fails_q   <= '0;
      seen_up_q <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      tick_q <= tick;
      if (tick_q && !seen_up_q) begin
        if (link_up_o) begin
          seen_up_q <= 1'b1;
        end else if (fails_q < ATT_MAX) begin
          fails_q <= fails_q + 1'b1;
          if (fails_q + 1'b1 == ATT_MAX) timeout_q <= 1'b1;
        end
      end
    end
  end

  assign timeout_o = timeout_q;

  a_r10_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(timeout_q));
  a_r10_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_q) |-> ($past(tick_q) && !link_up_o));
  a_r9_up_only_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up_o) |-> $past(tick));
endmodule

// File: tb/sim_lane_supervisor.sv
module sim_lane_supervisor;
  localparam int N     = 2;
  localparam int TICK  = 32;
  localparam int PULSE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    los, lock;
  logic [N*8-1:0]  err;
  logic [N*12-1:0] diag;
  logic [2*N-1:0]  ovr;
  logic [N*8-1:0]  ectl;
  logic [N-1:0]    down;
  logic            up, tmo;

  int checks = 0;
  int fails  = 0;
  int ec = 0;
  int last_eval = 0;

  always #5 clk = ~clk;

  lane_supervisor #(
    .NUM_LANES(N), .TICK_CYCLES(TICK), .PULSE_CYCLES(PULSE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .los_i(los), .lock_i(lock),
    .err_cnt_i(err), .diag_i(diag), .sigdet_ovr_o(ovr),
    .err_ctrl_o(ectl), .lane_down_o(down), .link_up_o(up), .timeout_o(tmo)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ec <= 0;
    else        ec <= ec + 1;
  end

  function automatic int diag_for(input int lf);
    return lf * 4;
  endfunction

  function automatic bit lf_out(input int lf);
    return (lf < 400) || (lf > 700);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_eval();
    do @(negedge clk); while (ec == 0 || (ec % TICK) != 0 || ec == last_eval);
    last_eval = ec;
  endtask

  task automatic wait_pre_eval();
    do @(negedge clk); while (((ec + 1) % TICK) != 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    los = '0; lock = '0; err = '0; diag = 24'(diag_for(500) | (diag_for(500) << 12));
    last_eval = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 ovr", int'(ovr), 0);
    check("R1 ectl", int'(ectl), 0);
    check("R1 down", int'(down), 0);
    check("R1 up", int'(up), 0);
    check("R1 tmo", int'(tmo), 0);
  endtask

  task automatic t_link_both();
    los = 2'b01; lock = 2'b11;
    wait_eval();
    check("R2 loss stays syncing ovr0", int'(ovr[1:0]), 0);
    check("R2 lane1 ovr3", int'(ovr[3:2]), 3);
    check("R9 one lane not up", int'(up), 0);
    los = 2'b00;
    wait_eval();
    check("R2 both ovr3", int'(ovr), 15);
    check("R9 all linked", int'(up), 1);
    @(negedge clk);
    check("R10 no timeout after up", int'(tmo), 0);
  endtask

  task automatic t_drop_regain();
    lock[0] = 1'b0;
    wait_eval();
    check("R5 down pulse", int'(down), 1);
    check("R5 ovr held", int'(ovr[1:0]), 3);
    check("R9 up drops", int'(up), 0);
    @(negedge clk);
    check("R5 down one clock", int'(down), 0);
    lock[0] = 1'b1;
    wait_eval();
    check("R6 relinked", int'(up), 1);
    check("R6 no down", int'(down), 0);
    check("R6 ovr3", int'(ovr[1:0]), 3);
  endtask

  task automatic t_sat_and_clear();
    err[15:8] = 8'hFF;
    wait_eval();
    check("R4 sat counts as no lock", int'(down), 2);
    check("R8 clear step1", int'(ectl[15:8]), 25);
    check("R8 lane0 untouched", int'(ectl[7:0]), 0);
    @(negedge clk);
    check("R8 clear step2", int'(ectl[15:8]), 0);
    err[15:8] = 8'h00;
    err[7:0]  = 8'h03;
    lock[1]   = 1'b0;
    diag[23:12] = 12'(diag_for(300));
    wait_eval();
    check("R8 small count clears", int'(ectl[7:0]), 25);
    check("R7 cdr pulse", int'(ovr[3:2]), 2);
    check("R7 lane0 ovr kept", int'(ovr[1:0]), 3);
    err[7:0] = 8'h00;
    repeat (PULSE - 1) @(negedge clk);
    check("R3 pulse still 2", int'(ovr[3:2]), 2);
    @(negedge clk);
    check("R3 pulse ends at 0", int'(ovr[3:2]), 0);
  endtask

  task automatic t_window();
    int lfs[4] = '{400, 700, 701, 399};
    for (int i = 0; i < 4; i++) begin
      diag[23:12] = 12'(diag_for(lfs[i]));
      wait_eval();
      check("R7 syncing no down", int'(down), 0);
      check("R3 window", int'(ovr[3:2]), lf_out(lfs[i]) ? 2 : 0);
      repeat (PULSE + 1) @(negedge clk);
    end
  endtask

  task automatic t_sync_delay();
    lock[1] = 1'b1;
    wait_eval();
    check("R9 back up", int'(up), 1);
    wait_pre_eval();
    lock[0] = 1'b0;
    check("R11 no change between ticks", int'(up), 1);
    wait_eval();
    check("R11 late change unseen", int'(down), 0);
    check("R11 still up", int'(up), 1);
    wait_eval();
    check("R11 seen next tick", int'(down), 1);
    lock[0] = 1'b1;
    wait_eval();
    check("R6 up again", int'(up), 1);
    check("R10 never timed out", int'(tmo), 0);
  endtask

  task automatic t_timeout();
    do_reset();
    lock = 2'b01;
    wait_eval();
    @(negedge clk);
    check("R10 first fail", int'(tmo), 0);
    wait_eval();
    @(negedge clk);
    check("R10 second fail", int'(tmo), 1);
    lock = 2'b11;
    wait_eval();
    check("R9 up", int'(up), 1);
    @(negedge clk);
    check("R10 sticky", int'(tmo), 1);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_link_both();
    t_drop_regain();
    t_sat_and_clear();
    t_window();
    t_sync_delay();
    t_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule